// File: doc/BRIEF.md
# Link Power Status Monitor

This block supervises the power state of the link controller attached to a serial-bus physical layer. It watches a level input that the link holds high while it is powered, and counts system-clock cycles while that input is low. A brief dropout is ignored. A dropout of moderate length makes the block issue a one-cycle reset to the PHY-to-link interface once the link returns. A long dropout shuts the interface off to save power, and the interface comes back as soon as the link reports power again. Repeater operation elsewhere in the PHY continues throughout.

While the interface is off, a link-on request pulse from the packet logic arms a wake-up clock. This clock is the system clock divided by a parameterized even ratio, with equal high and low times. The link can use it to power itself up. The clock keeps running until the power-status input and the link-active register bit are both high. The block also latches a contender strap while hardware reset is held, because the same board pin serves as an input during reset and as the wake-up output afterwards.

Top module: `lpm_top`

## Requirements
- R1: While `rst` is high, `contender` follows `contender_strap` at each clock edge. After reset is released, `contender` holds its value whatever `contender_strap` does.
- R2: On the first cycle after reset, `if_enable` is 1, `if_reset` is 0 and `linkon_out` is 0.
- R3: If `link_pwr` is low for SHORT_CYC or fewer clock edges and then returns high, neither `if_reset` nor `if_enable` changes.
- R4: If `link_pwr` is low for more than SHORT_CYC edges and returns high before the interface has been disabled, `if_reset` is high for exactly one cycle, on the cycle after the first edge that samples `link_pwr` high. This includes a dropout of exactly LONG_CYC edges.
- R5: If `link_pwr` is low for LONG_CYC+1 edges, `if_enable` is 0 after that edge. No `if_reset` pulse follows when the link returns.
- R6: While the interface is disabled, the first edge that samples `link_pwr` high sets `if_enable` back to 1.
- R7: A one-cycle `linkon_req` pulse sampled while `if_enable` is 0 starts `linkon_out`. After the arming edge, `linkon_out` stays low for LINKON_DIV/2 cycles and then toggles every LINKON_DIV/2 cycles, which gives a period of LINKON_DIV cycles at 50% duty.
- R8: A `linkon_req` pulse sampled while `if_enable` is 1 has no effect: `linkon_out` stays 0.
- R9: Once `linkon_out` is running, `link_pwr` high with `link_active` low does not stop it. When both are sampled high at the same edge, `linkon_out` is 0 within two edges and remains 0.
- R10: The inactivity count saturates at LONG_CYC. A dropout many times longer than LONG_CYC still leaves the interface disabled, re-enables it on return, and produces no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| link_pwr | input | 1 | Power status from the link controller, high while the link is powered |
| linkon_req | input | 1 | One-cycle pulse indicating that a link-on request was received |
| link_active | input | 1 | Link-active register bit |
| contender_strap | input | 1 | Level on the dual-purpose pin, sampled during reset |
| if_reset | output | 1 | One-cycle reset pulse to the PHY-to-link interface |
| if_enable | output | 1 | PHY-to-link interface enabled |
| linkon_out | output | 1 | Divided wake-up clock toward the link |
| contender | output | 1 | Latched bus-manager contender bit |

## Verification
The bound checker checks the following on every cycle:
- the reset pulse lasts one cycle and occurs only while the interface is enabled;
- the interface is disabled only after a saturated absence;
- the interface is re-enabled on the link's return;
- the inactivity count stays bounded and clears whenever power is present;
- the wake-up clock is armed only by a request that arrives while the interface is disabled, and it falls silent after disarming;
- the strap latch holds after reset.

Only the directed scenarios can show the following:
- the exact dropout lengths at the two window boundaries;
- the period and duty of the wake-up clock;
- that a request arriving while the interface is enabled is ignored;
- that `link_pwr` high without `link_active` leaves the clock running.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Interface supervisor state
    typedef enum logic {
        IFS_ON  = 1'b0,
        IFS_OFF = 1'b1
    } if_state_e;

    // Qualified view of the inactivity counter
    typedef struct packed {
        logic present;    // link reports power this cycle
        logic past_short; // absence longer than the short window
        logic saturated;  // absence reached the long window
    } idle_flags_t;

    // Width needed to hold a count from 0 to lim inclusive
    function automatic int unsigned count_width(input int unsigned lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer
    import lpm_pkg::*;
#(
    parameter int unsigned SHORT_CYC = 59,
    parameter int unsigned LONG_CYC  = 1229,
    localparam int unsigned CW = count_width(LONG_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          link_pwr,
    output logic [CW-1:0] cnt,
    output idle_flags_t   flags
);

    localparam logic [CW-1:0] LIM   = CW'(LONG_CYC);
    localparam logic [CW-1:0] SHORT = CW'(SHORT_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (link_pwr) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        flags.present    = link_pwr;
        flags.past_short = (cnt > SHORT);
        flags.saturated  = (cnt == LIM);
    end

endmodule

// File: rtl/lpm_if_ctrl.sv
module lpm_if_ctrl
    import lpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  idle_flags_t flags,
    output logic        if_enable,
    output logic        if_reset
);

    if_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IFS_ON:  if (!flags.present && flags.saturated) state_d = IFS_OFF;
            IFS_OFF: if (flags.present) state_d = IFS_ON;
            default: state_d = IFS_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= IFS_ON;
            if_reset <= 1'b0;
        end else begin
            state_q  <= state_d;
            if_reset <= (state_q == IFS_ON) && flags.present && flags.past_short;
        end
    end

    assign if_enable = (state_q == IFS_ON);

endmodule

// File: rtl/lpm_linkon_gen.sv
module lpm_linkon_gen
    import lpm_pkg::*;
#(
    parameter int unsigned LINKON_DIV = 8,
    localparam int unsigned HALF = LINKON_DIV / 2,
    localparam int unsigned PW   = count_width(HALF - 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic if_enable,
    input  logic link_pwr,
    input  logic link_active,
    output logic armed,
    output logic wake_clk
);

    localparam logic [PW-1:0] LAST = PW'(HALF - 1);

    logic [PW-1:0] phase;
    logic          stop;

    assign stop = link_pwr && link_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (stop) begin
            armed <= 1'b0;
        end else if (req && !if_enable) begin
            armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            phase    <= '0;
            wake_clk <= 1'b0;
        end else if (phase == LAST) begin
            phase    <= '0;
            wake_clk <= ~wake_clk;
        end else begin
            phase    <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/lpm_top.sv
module lpm_top
    import lpm_pkg::*;
#(
    parameter int unsigned SHORT_CYC  = 59,
    parameter int unsigned LONG_CYC   = 1229,
    parameter int unsigned LINKON_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic link_pwr,
    input  logic linkon_req,
    input  logic link_active,
    input  logic contender_strap,
    output logic if_reset,
    output logic if_enable,
    output logic linkon_out,
    output logic contender
);

    localparam int unsigned CW = count_width(LONG_CYC);

    logic [CW-1:0] idle_cnt;
    idle_flags_t   idle_flags;
    logic          linkon_armed;

    lpm_idle_timer #(
        .SHORT_CYC(SHORT_CYC),
        .LONG_CYC (LONG_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .link_pwr(link_pwr),
        .cnt     (idle_cnt),
        .flags   (idle_flags)
    );

    lpm_if_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .flags    (idle_flags),
        .if_enable(if_enable),
        .if_reset (if_reset)
    );

    lpm_linkon_gen #(
        .LINKON_DIV(LINKON_DIV)
    ) u_wake (
        .clk        (clk),
        .rst        (rst),
        .req        (linkon_req),
        .if_enable  (if_enable),
        .link_pwr   (link_pwr),
        .link_active(link_active),
        .armed      (linkon_armed),
        .wake_clk   (linkon_out)
    );

    // Dual-purpose pin: read as a strap while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            contender <= contender_strap;
        end
    end

endmodule

// File: rtl/lpm_checker.sv
module lpm_checker
    import lpm_pkg::*;
#(
    parameter int unsigned LONG_CYC = 1229,
    localparam int unsigned CW = count_width(LONG_CYC)
) (
    input logic          clk,
    input logic          rst,
    input logic          link_pwr,
    input logic          linkon_req,
    input logic          link_active,
    input logic          if_reset,
    input logic          if_enable,
    input logic          linkon_out,
    input logic          contender,
    input logic [CW-1:0] idle_cnt,
    input logic          linkon_armed
);

    p_strap_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(contender));

    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
        link_pwr |=> (idle_cnt == '0));

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        if_reset |=> !if_reset);

    p_pulse_enabled_r4: assert property (@(posedge clk) disable iff (rst)
        if_reset |-> if_enable);

    p_disable_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(if_enable) |-> ($past(!link_pwr) && ($past(idle_cnt) == CW'(LONG_CYC))));

    p_reenable_r6: assert property (@(posedge clk) disable iff (rst)
        (!if_enable && link_pwr) |=> if_enable);

    p_arm_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(linkon_armed) |-> $past(linkon_req && !if_enable));

    p_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (link_pwr && link_active) |=> !linkon_armed);

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!linkon_armed && $past(!linkon_armed)) |-> !linkon_out);

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        idle_cnt <= CW'(LONG_CYC));

endmodule

bind lpm_top lpm_checker #(.LONG_CYC(LONG_CYC)) u_chk (.*);

// File: tb/lpm_top_test.sv
module lpm_top_test;

    localparam int SHORT = 59;
    localparam int LONG  = 1229;
    localparam int DIV   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_pwr = 1'b1;
    logic linkon_req = 1'b0;
    logic link_active = 1'b0;
    logic contender_strap = 1'b0;
    logic if_reset, if_enable, linkon_out, contender;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lpm_top #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .LINKON_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .link_pwr(link_pwr), .linkon_req(linkon_req),
        .link_active(link_active), .contender_strap(contender_strap),
        .if_reset(if_reset), .if_enable(if_enable), .linkon_out(linkon_out),
        .contender(contender)
    );

    always @(negedge clk) if (!rst && if_reset) pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst = 1'b1;
        contender_strap = strap;
        link_pwr = 1'b1;
        link_active = 1'b0;
        linkon_req = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        pulses = 0;
    endtask

    // Hold link_pwr low for n edges, then restore; leaves caller at the
    // negedge after the first high-sampling edge.
    task automatic dropout(input int n, output int en_before);
        link_pwr = 1'b0;
        repeat (n) @(negedge clk);
        en_before = if_enable;
        link_pwr = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_strap();
        int v;
        do_reset(1'b1);
        check(contender == 1'b1, "R1 strap high", contender, 1);
        check(if_enable == 1'b1, "R2 enable after reset", if_enable, 1);
        check(if_reset == 1'b0, "R2 no reset pulse", if_reset, 0);
        check(linkon_out == 1'b0, "R2 linkon idle", linkon_out, 0);
        contender_strap = 1'b0;
        repeat (5) @(negedge clk);
        check(contender == 1'b1, "R1 hold after reset", contender, 1);
        do_reset(1'b0);
        check(contender == 1'b0, "R1 strap low", contender, 0);
        contender_strap = 1'b1;
        dropout(10, v);
        check(contender == 1'b0, "R1 hold low", contender, 0);
    endtask

    task automatic t_short_window();
        int en;
        pulses = 0;
        dropout(SHORT, en);
        repeat (3) @(negedge clk);
        check(pulses == 0, "R3 short dropout no pulse", pulses, 0);
        check(if_enable == 1'b1, "R3 enable kept", if_enable, 1);
        pulses = 0;
        dropout(SHORT + 1, en);
        check(if_reset == 1'b1, "R4 pulse at SHORT+1", if_reset, 1);
        @(negedge clk);
        check(if_reset == 1'b0, "R4 pulse one cycle", if_reset, 0);
        check(pulses == 1, "R4 single pulse", pulses, 1);
        pulses = 0;
        dropout(LONG, en);
        check(en == 1, "R4 still enabled at LONG", en, 1);
        check(if_reset == 1'b1, "R4 pulse at LONG", if_reset, 1);
        repeat (2) @(negedge clk);
        check(pulses == 1, "R4 single pulse at LONG", pulses, 1);
    endtask

    task automatic t_long_window(input int n, input string req);
        int en;
        pulses = 0;
        dropout(n, en);
        check(en == 0, {req, " disabled"}, en, 0);
        check(if_enable == 1'b1, "R6 re-enabled", if_enable, 1);
        repeat (3) @(negedge clk);
        check(pulses == 0, {req, " no pulse on return"}, pulses, 0);
    endtask

    task automatic t_linkon();
        int highs, rises;
        logic prev;
        link_pwr = 1'b0;
        repeat (LONG + 1) @(negedge clk);
        check(if_enable == 1'b0, "R5 off before request", if_enable, 0);
        linkon_req = 1'b1;
        @(negedge clk);
        linkon_req = 1'b0;
        highs = 0; rises = 0; prev = linkon_out;
        for (int k = 1; k <= 8 * DIV; k++) begin
            @(negedge clk);
            if (k == DIV / 2 - 1) check(linkon_out == 1'b0, "R7 low first half", linkon_out, 0);
            if (k == DIV / 2) check(linkon_out == 1'b1, "R7 first rise", linkon_out, 1);
            if (linkon_out) highs++;
            if (linkon_out && !prev) rises++;
            prev = linkon_out;
        end
        check(highs == 4 * DIV, "R7 duty", highs, 4 * DIV);
        check(rises == 8, "R7 period", rises, 8);
        link_pwr = 1'b1;
        rises = 0; prev = linkon_out;
        for (int k = 0; k < 4 * DIV; k++) begin
            @(negedge clk);
            if (linkon_out && !prev) rises++;
            prev = linkon_out;
        end
        check(rises == 4, "R9 runs without link_active", rises, 4);
        link_active = 1'b1;
        repeat (2) @(negedge clk);
        check(linkon_out == 1'b0, "R9 stopped", linkon_out, 0);
        highs = 0;
        for (int k = 0; k < 3 * DIV; k++) begin
            @(negedge clk);
            if (linkon_out) highs++;
        end
        check(highs == 0, "R9 stays stopped", highs, 0);
    endtask

    task automatic t_request_enabled();
        int highs = 0;
        link_active = 1'b0;
        link_pwr = 1'b1;
        @(negedge clk);
        linkon_req = 1'b1;
        @(negedge clk);
        linkon_req = 1'b0;
        for (int k = 0; k < 4 * DIV; k++) begin
            @(negedge clk);
            if (linkon_out) highs++;
        end
        check(highs == 0, "R8 request ignored when enabled", highs, 0);
    endtask

    initial begin
        t_reset_strap();
        t_short_window();
        t_long_window(LONG + 1, "R5");
        t_long_window(3 * LONG + 7, "R10");
        t_linkon();
        t_request_enabled();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule